// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit works out the 16-bit effective address of a memory operand for an 8-bit processor. The decoder pulses `start_i` for one cycle and presents a 4-bit mode code, up to two operand bytes that were already taken from the instruction stream, and the current X index value. Direct and indexed forms are resolved arithmetically. Indirect forms first read a pointer from page zero through a byte-wide synchronous read port, then index it if the mode asks for that.

The result appears on `ea_o` together with a one-cycle `done_o` pulse. Modes that address no memory return at once with `no_addr_o` set. While a pointer fetch is in flight `busy_o` is high, and any further start is dropped. Short forms stay in page zero, or reach up to 0x1FE when X is added. The addition keeps its carry and does not fold back into page zero.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and right after it is released, `done_o`, `busy_o`, `mem_re_o` and `no_addr_o` are low and `ea_o` is 0.
- R2: Mode 4 (short direct) returns `{8'h00, op_lo_i}`, with `done_o` high in the cycle after the start edge.
- R3: Mode 5 (long direct) returns `{op_hi_i, op_lo_i}`, with `done_o` high in the cycle after the start edge.
- R4: Mode 6 (indexed, no offset) returns `{8'h00, x_i}`, with `done_o` high in the cycle after the start edge.
- R5: Mode 7 (short indexed) returns `op_lo_i + x_i` as a 9-bit sum with the carry kept, so the largest value is 0x1FE. The result is ready one cycle after the start edge.
- R6: Mode 8 (long indexed) returns `{op_hi_i, op_lo_i} + x_i` modulo 2^16, one cycle after the start edge.
- R7: Mode 9 (short indirect) reads the byte at page-zero address `op_lo_i`, and that byte is the address. There is exactly one read, in the cycle after the start edge, and `done_o` comes three cycles after the start edge.
- R8: Mode 10 (long indirect) reads a word pointer, high byte at `op_lo_i` and low byte at `op_lo_i+1` modulo 256. The two reads are in consecutive cycles, and `done_o` comes four cycles after the start edge.
- R9: Mode 11 (short indirect indexed) adds the byte pointer read as in R7 to the latched X with the carry kept, giving at most 0x1FE. `done_o` comes three cycles after the start edge.
- R10: Mode 12 (long indirect indexed) adds the word pointer read as in R8 to the latched X modulo 2^16. `done_o` comes four cycles after the start edge.
- R11: Codes 0–3 (inherent, immediate, relative, bit) and 13–15 give `done_o` with `no_addr_o`=1 and `ea_o`=0 in the cycle after the start edge, with no memory read.
- R12: A start pulse while `busy_o` is high is ignored. The running result, its timing and its reads are unchanged, and no extra `done_o` follows.
- R13: `busy_o` is high from the cycle after an indirect start until the cycle before `done_o`, and `mem_re_o` is high only in pointer-read cycles. `done_o` lasts one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to compute an address |
| mode_i | input | 4 | Addressing mode code |
| op_hi_i | input | 8 | High operand byte (long forms) |
| op_lo_i | input | 8 | Low operand byte, offset or pointer location |
| x_i | input | 8 | X index register value |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the read request |
| mem_re_o | output | 1 | Page-zero read request |
| mem_addr_o | output | 8 | Page-zero read address |
| busy_o | output | 1 | Pointer fetch in progress; starts are dropped |
| done_o | output | 1 | One-cycle result pulse |
| no_addr_o | output | 1 | Mode needs no memory address |
| ea_o | output | 16 | Effective address, held until the next result |

## Verification
Direct, indexed and non-address modes deliver their result one cycle after the start edge. Byte-pointer modes deliver three cycles after it, and word-pointer modes four. The bench reference model computes that latency for each operation from the mode code and samples at the falling edge of every cycle after the start. In each of those cycles it compares `done_o`, `busy_o`, `mem_re_o` and `mem_addr_o` with the model, and it compares `ea_o` and `no_addr_o` in the `done_o` cycle. One more cycle is checked to confirm that the pulse has ended. Operands and X are scrambled right after the start edge so that any late sampling shows up. Stray starts are injected in every busy cycle to show that they change neither the timing nor the result.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  localparam logic [3:0] AM_INH    = 4'd0;
  localparam logic [3:0] AM_IMM    = 4'd1;
  localparam logic [3:0] AM_REL    = 4'd2;
  localparam logic [3:0] AM_BIT    = 4'd3;
  localparam logic [3:0] AM_DIR_S  = 4'd4;
  localparam logic [3:0] AM_DIR_L  = 4'd5;
  localparam logic [3:0] AM_IDX_0  = 4'd6;
  localparam logic [3:0] AM_IDX_S  = 4'd7;
  localparam logic [3:0] AM_IDX_L  = 4'd8;
  localparam logic [3:0] AM_IND_S  = 4'd9;
  localparam logic [3:0] AM_IND_L  = 4'd10;
  localparam logic [3:0] AM_INDX_S = 4'd11;
  localparam logic [3:0] AM_INDX_L = 4'd12;

  typedef struct packed {
    logic no_addr;
    logic indirect;
    logic word_ptr;
    logic long_op;
    logic indexed;
    logic zero_base;
    logic short_res;
  } mode_attr_t;

  function automatic mode_attr_t decode_mode(input logic [3:0] m);
    mode_attr_t a;
    a = '0;
    case (m)
      AM_DIR_S:  a.short_res = 1'b1;
      AM_DIR_L:  a.long_op   = 1'b1;
      AM_IDX_0:  begin a.indexed = 1'b1; a.zero_base = 1'b1; a.short_res = 1'b1; end
      AM_IDX_S:  begin a.indexed = 1'b1; a.short_res = 1'b1; end
      AM_IDX_L:  begin a.indexed = 1'b1; a.long_op = 1'b1; end
      AM_IND_S:  begin a.indirect = 1'b1; a.short_res = 1'b1; end
      AM_IND_L:  begin a.indirect = 1'b1; a.word_ptr = 1'b1; end
      AM_INDX_S: begin a.indirect = 1'b1; a.indexed = 1'b1; a.short_res = 1'b1; end
      AM_INDX_L: begin a.indirect = 1'b1; a.word_ptr = 1'b1; a.indexed = 1'b1; end
      default:   a.no_addr = 1'b1;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] sum_o
);
  // zero-extended index: short bases keep the carry into bit IDX_W
  always_comb sum_o = en_i ? base_i + ADDR_W'(idx_i) : base_i;
endmodule

// File: rtl/ea_ptr_fsm.sv
module ea_ptr_fsm #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  input  logic                  word_i,
  input  logic [BYTE_W-1:0]     ptr_i,
  input  logic [BYTE_W-1:0]     mem_rdata_i,
  output logic                  mem_re_o,
  output logic [BYTE_W-1:0]     mem_addr_o,
  output logic                  busy_o,
  output logic                  fin_o,
  output logic [2*BYTE_W-1:0]   ptr_val_o
);
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {S_IDLE, S_RD_FIRST, S_RD_SECOND, S_FIN} state_e;

  state_e            state_q;
  logic [BYTE_W-1:0] ptr_q;
  logic [BYTE_W-1:0] hi_q;
  logic              word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      hi_q    <= '0;
      word_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (launch_i) begin
          ptr_q   <= ptr_i;
          word_q  <= word_i;
          state_q <= S_RD_FIRST;
        end
        S_RD_FIRST:  state_q <= word_q ? S_RD_SECOND : S_FIN;
        S_RD_SECOND: begin
          hi_q    <= mem_rdata_i; // data of the first read
          state_q <= S_FIN;
        end
        default:     state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_re_o   = (state_q == S_RD_FIRST) || (state_q == S_RD_SECOND);
    mem_addr_o = (state_q == S_RD_SECOND) ? ptr_q + BYTE_W'(1) : ptr_q; // wraps in page zero
    busy_o     = (state_q != S_IDLE);
    fin_o      = (state_q == S_FIN);
    ptr_val_o  = word_q ? {hi_q, mem_rdata_i} : ADDR_W'(mem_rdata_i);
  end

  a_r12_no_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !launch_i);
  a_r8_second_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD_SECOND) |-> mem_addr_o == BYTE_W'($past(mem_addr_o) + 1'b1));
  a_r7_byte_read_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !word_q) |=> fin_o);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [3:0]          mode_i,
  input  logic [BYTE_W-1:0]   op_hi_i,
  input  logic [BYTE_W-1:0]   op_lo_i,
  input  logic [BYTE_W-1:0]   x_i,
  input  logic [BYTE_W-1:0]   mem_rdata_i,
  output logic                mem_re_o,
  output logic [BYTE_W-1:0]   mem_addr_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                no_addr_o,
  output logic [2*BYTE_W-1:0] ea_o
);
  localparam int ADDR_W    = 2 * BYTE_W;
  localparam int SHORT_MAX = 2 * ((1 << BYTE_W) - 1);

  mode_attr_t        attr;
  logic              accept, launch, fsm_busy, fsm_fin;
  logic [ADDR_W-1:0] dir_base, dir_ea, ptr_val, ptr_ea;
  logic [BYTE_W-1:0] x_q;
  logic              idx_q, short_q, indirect_q;
  logic              done_q, no_addr_q;
  logic [ADDR_W-1:0] ea_q;

  always_comb begin
    attr   = decode_mode(mode_i);
    accept = start_i && !fsm_busy;
    launch = accept && attr.indirect;
    if (attr.zero_base)    dir_base = '0;
    else if (attr.long_op) dir_base = {op_hi_i, op_lo_i};
    else                   dir_base = ADDR_W'(op_lo_i);
  end

  ea_index_add #(.ADDR_W(ADDR_W), .IDX_W(BYTE_W)) u_dir_add (
    .base_i (dir_base),
    .idx_i  (x_i),
    .en_i   (attr.indexed),
    .sum_o  (dir_ea)
  );

  ea_ptr_fsm #(.BYTE_W(BYTE_W)) u_ptr_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .word_i      (attr.word_ptr),
    .ptr_i       (op_lo_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (fsm_busy),
    .fin_o       (fsm_fin),
    .ptr_val_o   (ptr_val)
  );

  ea_index_add #(.ADDR_W(ADDR_W), .IDX_W(BYTE_W)) u_ptr_add (
    .base_i (ptr_val),
    .idx_i  (x_q),
    .en_i   (idx_q),
    .sum_o  (ptr_ea)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      no_addr_q  <= 1'b0;
      ea_q       <= '0;
      x_q        <= '0;
      idx_q      <= 1'b0;
      short_q    <= 1'b0;
      indirect_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fsm_fin) begin
        done_q    <= 1'b1;
        no_addr_q <= 1'b0;
        ea_q      <= ptr_ea;
      end else if (accept) begin
        x_q        <= x_i;
        idx_q      <= attr.indexed;
        short_q    <= attr.short_res;
        indirect_q <= attr.indirect;
        if (attr.no_addr) begin
          done_q    <= 1'b1;
          no_addr_q <= 1'b1;
          ea_q      <= '0;
        end else if (!attr.indirect) begin
          done_q    <= 1'b1;
          no_addr_q <= 1'b0;
          ea_q      <= dir_ea;
        end
      end
    end
  end

  assign busy_o    = fsm_busy;
  assign done_o    = done_q;
  assign no_addr_o = no_addr_q;
  assign ea_o      = ea_q;

  a_r13_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_short_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && short_q) |-> (ea_o <= ADDR_W'(SHORT_MAX)));
  a_r11_noaddr_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && no_addr_o) |-> (ea_o == '0 && !$past(mem_re_o)));
  a_r7_read_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && indirect_q) |-> $past(mem_re_o, 2));
endmodule

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
  import ea_gen_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_hi = '0, op_lo = '0, x = '0;
  logic [7:0]  mem_rdata = '0;
  logic        mem_re, busy, done, no_addr;
  logic [7:0]  mem_addr;
  logic [15:0] ea;
  logic [7:0]  pmem [0:255];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ea_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .mode_i(mode),
    .op_hi_i(op_hi), .op_lo_i(op_lo), .x_i(x), .mem_rdata_i(mem_rdata),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .busy_o(busy),
    .done_o(done), .no_addr_o(no_addr), .ea_o(ea)
  );

  // page-zero memory, one cycle read latency
  always @(posedge clk) if (mem_re) mem_rdata <= pmem[mem_addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_ea(input logic [3:0] m, input logic [7:0] hi,
                                        input logic [7:0] lo, input logic [7:0] xi);
    logic [15:0] w;
    w = {pmem[lo], pmem[8'(lo + 8'd1)]};
    case (m)
      AM_DIR_S:  return {8'h00, lo};
      AM_DIR_L:  return {hi, lo};
      AM_IDX_0:  return {8'h00, xi};
      AM_IDX_S:  return 16'(lo) + 16'(xi);
      AM_IDX_L:  return {hi, lo} + 16'(xi);
      AM_IND_S:  return {8'h00, pmem[lo]};
      AM_IND_L:  return w;
      AM_INDX_S: return 16'(pmem[lo]) + 16'(xi);
      AM_INDX_L: return w + 16'(xi);
      default:   return 16'h0000;
    endcase
  endfunction

  // start on a falling edge; model every following cycle; inj>0 fires a stray start then
  task automatic run_op(input string tag, input logic [3:0] m, input logic [7:0] hi,
                        input logic [7:0] lo, input logic [7:0] xi, input int inj);
    int lat;
    bit ind, word, na;
    logic [15:0] exp;
    ind  = (m >= AM_IND_S) && (m <= AM_INDX_L);
    word = (m == AM_IND_L) || (m == AM_INDX_L);
    na   = (m < AM_DIR_S) || (m > AM_INDX_L);
    lat  = !ind ? 1 : (word ? 4 : 3);
    exp  = ref_ea(m, hi, lo, xi);
    start = 1'b1; mode = m; op_hi = hi; op_lo = lo; x = xi;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      check({tag, " R13 done"}, 32'(done), 32'(n == lat));
      check({tag, " R13 busy"}, 32'(busy), 32'(ind && n < lat));
      check({tag, na ? " R11 read" : " R13 read"}, 32'(mem_re),
            32'(ind && (n == 1 || (word && n == 2))));
      if (mem_re) check({tag, " R8 read addr"}, 32'(mem_addr), 32'(8'(lo + 8'(n - 1))));
      if (n == lat) begin
        check({tag, " ea"}, 32'(ea), 32'(exp));
        check({tag, " R11 no_addr"}, 32'(no_addr), 32'(na));
      end
      start = 1'b0;
      op_hi = ~hi; op_lo = ~lo; x = ~xi;   // late sampling would show
      if (inj != 0 && n == inj) begin
        start = 1'b1; mode = AM_DIR_S; op_lo = 8'h5A;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pmem[i] = 8'(i * 37 + 11);
    pmem[8'h20] = 8'h9C;
    pmem[8'h30] = 8'hAB; pmem[8'h31] = 8'hCD;
    pmem[8'hFF] = 8'h12; pmem[8'h00] = 8'h34;
    pmem[8'h40] = 8'hFF;
    pmem[8'h50] = 8'hFF; pmem[8'h51] = 8'hC0;

    repeat (2) @(negedge clk);
    check("R1 done in reset", 32'(done), 0);
    check("R1 busy in reset", 32'(busy), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 done", 32'(done), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 mem_re", 32'(mem_re), 0);
    check("R1 no_addr", 32'(no_addr), 0);
    check("R1 ea", 32'(ea), 0);

    run_op("R2", AM_DIR_S, 8'hEE, 8'h37, 8'h11, 0);
    run_op("R2", AM_DIR_S, 8'h00, 8'hFF, 8'hFF, 0);
    run_op("R3", AM_DIR_L, 8'h12, 8'h34, 8'h01, 0);
    run_op("R3", AM_DIR_L, 8'hFF, 8'hFF, 8'h80, 0);
    run_op("R4", AM_IDX_0, 8'h77, 8'h66, 8'hA5, 0);
    run_op("R5", AM_IDX_S, 8'h00, 8'hFF, 8'hFF, 0);
    run_op("R5", AM_IDX_S, 8'h99, 8'h10, 8'h05, 0);
    run_op("R6", AM_IDX_L, 8'hFF, 8'hF0, 8'h20, 0);
    run_op("R6", AM_IDX_L, 8'h10, 8'h00, 8'h7F, 0);
    run_op("R7", AM_IND_S, 8'h55, 8'h20, 8'h33, 0);
    run_op("R8", AM_IND_L, 8'h00, 8'h30, 8'h44, 0);
    run_op("R8", AM_IND_L, 8'h00, 8'hFF, 8'h00, 0);
    run_op("R9", AM_INDX_S, 8'h00, 8'h40, 8'hFF, 0);
    run_op("R9", AM_INDX_S, 8'h00, 8'h20, 8'h01, 0);
    run_op("R10", AM_INDX_L, 8'h00, 8'h50, 8'h80, 0);
    run_op("R10", AM_INDX_L, 8'h00, 8'h30, 8'h10, 0);
    run_op("R11", AM_INH, 8'h12, 8'h34, 8'h56, 0);
    run_op("R11", AM_IMM, 8'h12, 8'h34, 8'h56, 0);
    run_op("R11", AM_REL, 8'h12, 8'h34, 8'h56, 0);
    run_op("R11", AM_BIT, 8'h12, 8'h34, 8'h56, 0);
    run_op("R11", 4'd13, 8'h12, 8'h34, 8'h56, 0);
    run_op("R11", 4'd15, 8'h12, 8'h34, 8'h56, 0);
    run_op("R12", AM_IND_L, 8'h00, 8'h30, 8'h00, 1);
    run_op("R12", AM_IND_L, 8'h00, 8'h30, 8'h00, 2);
    run_op("R12", AM_INDX_L, 8'h00, 8'h50, 8'h80, 3);
    run_op("R12", AM_IND_S, 8'h00, 8'h20, 8'h00, 1);
    run_op("R12", AM_INDX_S, 8'h00, 8'h40, 8'hFF, 2);
    run_op("R2", AM_DIR_S, 8'h00, 8'h01, 8'h00, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule